// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

The block gathers up to 32 peripheral interrupt causes and one watchdog event, and presents a single winning request to the processor. Each cause is a sticky flag. An event sets the flag, and it stays set until software clears it with a write-one-to-clear. A flag only competes for arbitration while its per-source enable bit is also set. Because the request is level-based, turning on an enable while the flag is already set raises the request at once.

Among the active requests, the block picks the one with the numerically lowest two-bit priority code. On a tie, the lowest source index wins. A watchdog event routed to the non-maskable path beats every peripheral request, whatever the enables are. For the winner the block outputs the exception number and the address of its vector slot. The slot address is computed from a relocatable table base register. A small word-addressed write port sets the registers, and a combinational read port returns them.

Top module: `irq_vector_arbiter`

## Requirements
- R1: The table base register (word 0x00) resets to 0 and takes any later written value. Bits [1:0] are not stored and read back as 0.
- R2: While a peripheral source k wins, irq_excnum is k + 16 and vec_addr is base + 4 × (k + 16). For example, source 22 gives base + 0x98 and source 27 gives base + 0xAC.
- R3: An irq_event pulse on source k sets flag k (bit k of word 0x08). The flag stays set until a write to word 0x08 with bit k = 1. When that write and a new event arrive in the same cycle, the flag stays set.
- R4: Source k requests only while both flag k and enable k (bit k of word 0x04) are 1. Setting the enable while the flag is already 1 raises the request in the cycle after the write, with no new event.
- R5: The priority of source k sits at bits [8(k mod 4)+7 : 8(k mod 4)+6] of word 0x10 + 4·⌊k/4⌋. Among active requests the lowest code wins. The other six bits of each byte are ignored and read back as 0.
- R6: Among active requests with equal priority codes, the lowest source index wins.
- R7: When control bit 0 (word 0x0C) is 1, a wdt_event sets a pending non-maskable request, shown on nmi_active and on control read bit 1. This request wins over every peripheral source regardless of enables, with irq_excnum = 2 and vec_addr = base + 8. It stays pending until a write to word 0x0C with bit 1 = 1.
- R8: When control bit 0 is 0, its reset value, a wdt_event gives a one-cycle sys_reset_req pulse in the next cycle and no non-maskable request.
- R9: With no active request, irq_valid, irq_excnum and vec_addr are all 0.
- R10: After reset, all flags, enables and priority fields are 0 and the non-maskable request is not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the written word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read word |
| rd_data | output | 32 | Read data (combinational) |
| irq_event | input | 32 | One-cycle cause events, one bit per source |
| wdt_event | input | 1 | Watchdog expiry event |
| irq_valid | output | 1 | A request is being presented |
| irq_excnum | output | 6 | Exception number of the winner |
| vec_addr | output | 32 | Vector slot address of the winner |
| nmi_active | output | 1 | Non-maskable request pending |
| sys_reset_req | output | 1 | Watchdog reset pulse |

## Verification
The hardest case to reach from the ports is a same-cycle collision. One is a clear of a flag together with a fresh event on that same flag. Another is the non-maskable request arriving while peripheral requests of every priority are already pending. The bench reaches both by driving the write port and the event inputs in the same clock cycle. It also builds up many set flags behind cleared enables, and then releases them with a single enable write. For the priority order it sweeps every pair of codes on two fixed sources, so each strict order and each tie is seen.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int WORD_BASE  = 0;
    localparam int WORD_EN    = 1;
    localparam int WORD_FLAG  = 2;
    localparam int WORD_CTRL  = 3;
    localparam int WORD_PRIO0 = 4;
    localparam int EXC_NMI    = 2;
    localparam int EXC_IRQ0   = 16;
    localparam int PRIO_BITS  = 2;
    typedef logic [PRIO_BITS-1:0] prio_code_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [5:0]              wr_word,
    input  logic [31:0]             wr_data,
    output logic [AW-3:0]           base_o,
    output logic [N-1:0]            en_o,
    output logic [N-1:0][PRIO_BITS-1:0] prio_o,
    output logic                    route_o
);
    localparam int PW = (N + 3) / 4;

    typedef struct packed {
        logic [AW-3:0]                 base;
        logic [N-1:0]                  en;
        logic [N-1:0][PRIO_BITS-1:0]   prio;
        logic                          route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (int'(wr_word))
                WORD_BASE: cfg_d.base  = wr_data[AW-1:2];
                WORD_EN:   cfg_d.en    = wr_data[N-1:0];
                WORD_CTRL: cfg_d.route = wr_data[0];
                default: begin
                    if (int'(wr_word) >= WORD_PRIO0 && int'(wr_word) < WORD_PRIO0 + PW) begin
                        for (int k = 0; k < 4; k++) begin
                            int idx;
                            idx = (int'(wr_word) - WORD_PRIO0) * 4 + k;
                            if (idx < N)
                                cfg_d.prio[idx] = wr_data[8*k+6 +: PRIO_BITS];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_o  = cfg_q.base;
    assign en_o    = cfg_q.en;
    assign prio_o  = cfg_q.prio;
    assign route_o = cfg_q.route;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic         wdt_i,
    input  logic         route_i,
    input  logic         nmi_clr_i,
    output logic [N-1:0] flag_o,
    output logic         nmi_o,
    output logic         rst_req_o
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic         nmi;
        logic         rst_req;
    } fb_t;

    fb_t fb_d, fb_q;

    always_comb begin
        fb_d         = fb_q;
        fb_d.flag    = (fb_q.flag & ~clr_i) | evt_i;
        fb_d.nmi     = (fb_q.nmi & ~nmi_clr_i) | (wdt_i & route_i);
        fb_d.rst_req = wdt_i & ~route_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign flag_o    = fb_q.flag;
    assign nmi_o     = fb_q.nmi;
    assign rst_req_o = fb_q.rst_req;
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]                active_i,
    input  logic [N-1:0][PRIO_BITS-1:0] prio_i,
    output logic                        hit_o,
    output logic [IW-1:0]               win_o
);
    always_comb begin
        prio_code_t best;
        hit_o = 1'b0;
        win_o = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (active_i[i] && (!hit_o || prio_i[i] < best)) begin
                hit_o = 1'b1;
                best  = prio_i[i];
                win_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
    import irq_arb_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 5,
    parameter int EW = 6
) (
    input  logic          nmi_i,
    input  logic          hit_i,
    input  logic [IW-1:0] win_i,
    input  logic [AW-3:0] base_i,
    output logic          valid_o,
    output logic [EW-1:0] exc_o,
    output logic [AW-1:0] addr_o
);
    always_comb begin
        valid_o = nmi_i | hit_i;
        exc_o   = '0;
        addr_o  = '0;
        if (nmi_i)
            exc_o = EW'(EXC_NMI);
        else if (hit_i)
            exc_o = EW'(win_i) + EW'(EXC_IRQ0);
        if (valid_o)
            addr_o = {base_i, 2'b00} + AW'({exc_o, 2'b00});
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 32,
    parameter int IW = $clog2(N),
    parameter int EW = $clog2(N + EXC_IRQ0)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [7:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic [N-1:0]  irq_event,
    input  logic          wdt_event,
    output logic          irq_valid,
    output logic [EW-1:0] irq_excnum,
    output logic [AW-1:0] vec_addr,
    output logic          nmi_active,
    output logic          sys_reset_req
);
    localparam int PW = (N + 3) / 4;

    logic [5:0]                  wr_word, rd_word;
    logic [AW-3:0]               cfg_base;
    logic [N-1:0]                cfg_en;
    logic [N-1:0][PRIO_BITS-1:0] cfg_prio;
    logic                        cfg_route;
    logic [N-1:0]                flags, clr_mask;
    logic                        nmi_clr;
    logic                        hit;
    logic [IW-1:0]               win;

    assign wr_word  = wr_addr[7:2];
    assign rd_word  = rd_addr[7:2];
    assign clr_mask = (wr_en && int'(wr_word) == WORD_FLAG) ? wr_data[N-1:0] : '0;
    assign nmi_clr  = wr_en && int'(wr_word) == WORD_CTRL && wr_data[1];

    irq_cfg_regs #(.N(N), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .base_o(cfg_base), .en_o(cfg_en), .prio_o(cfg_prio), .route_o(cfg_route)
    );

    irq_flag_bank #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(irq_event), .clr_i(clr_mask),
        .wdt_i(wdt_event), .route_i(cfg_route), .nmi_clr_i(nmi_clr),
        .flag_o(flags), .nmi_o(nmi_active), .rst_req_o(sys_reset_req)
    );

    irq_prio_select #(.N(N), .IW(IW)) u_sel (
        .active_i(flags & cfg_en), .prio_i(cfg_prio), .hit_o(hit), .win_o(win)
    );

    irq_vec_gen #(.AW(AW), .IW(IW), .EW(EW)) u_vec (
        .nmi_i(nmi_active), .hit_i(hit), .win_i(win), .base_i(cfg_base),
        .valid_o(irq_valid), .exc_o(irq_excnum), .addr_o(vec_addr)
    );

    always_comb begin
        rd_data = '0;
        case (int'(rd_word))
            WORD_BASE: rd_data[AW-1:0] = {cfg_base, 2'b00};
            WORD_EN:   rd_data[N-1:0]  = cfg_en;
            WORD_FLAG: rd_data[N-1:0]  = flags;
            WORD_CTRL: rd_data[1:0]    = {nmi_active, cfg_route};
            default: begin
                if (int'(rd_word) >= WORD_PRIO0 && int'(rd_word) < WORD_PRIO0 + PW) begin
                    for (int k = 0; k < 4; k++) begin
                        int idx;
                        idx = (int'(rd_word) - WORD_PRIO0) * 4 + k;
                        if (idx < N)
                            rd_data[8*k+6 +: PRIO_BITS] = cfg_prio[idx];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int AW = 32,
    parameter int EW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wdt_event,
    input logic          irq_valid,
    input logic [EW-1:0] irq_excnum,
    input logic [AW-1:0] vec_addr,
    input logic          nmi_active,
    input logic          sys_reset_req,
    input logic [AW-3:0] cfg_base,
    input logic          cfg_route
);
    p_vec_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> vec_addr == ({cfg_base, 2'b00} + AW'({irq_excnum, 2'b00})));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !wr_en) |=> irq_valid);

    p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_active && !wr_en) |=> nmi_active);

    p_nmi_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_active |-> (irq_valid && irq_excnum == EW'(2)));

    p_sysreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_event && !cfg_route) |=> sys_reset_req);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (vec_addr == '0 && irq_excnum == '0));
endmodule

bind irq_vector_arbiter irq_arb_chk #(.AW(AW), .EW(EW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdt_event(wdt_event),
    .irq_valid(irq_valid), .irq_excnum(irq_excnum), .vec_addr(vec_addr),
    .nmi_active(nmi_active), .sys_reset_req(sys_reset_req),
    .cfg_base(cfg_base), .cfg_route(cfg_route)
);

// File: tb/sim_irq_vector_arbiter.sv
module sim_irq_vector_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] irq_event = '0;
    logic        wdt_event = 1'b0;
    logic        irq_valid;
    logic [5:0]  irq_excnum;
    logic [31:0] vec_addr;
    logic        nmi_active;
    logic        sys_reset_req;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_event(irq_event), .wdt_event(wdt_event),
        .irq_valid(irq_valid), .irq_excnum(irq_excnum), .vec_addr(vec_addr),
        .nmi_active(nmi_active), .sys_reset_req(sys_reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [N-1:0] m);
        @(negedge clk);
        irq_event = m;
        @(negedge clk);
        irq_event = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic expect_irq(input string req, input int k);
        chk({req, " valid"}, 32'(irq_valid), 32'd1);
        chk({req, " excnum"}, 32'(irq_excnum), 32'(k + 16));
        chk({req, " addr"}, vec_addr, base + 32'(4 * (k + 16)));
    endtask

    task automatic expect_idle(input string req);
        chk({req, " valid"}, 32'(irq_valid), 32'd0);
        chk({req, " excnum"}, 32'(irq_excnum), 32'd0);
        chk({req, " addr"}, vec_addr, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1 / R9: reset state
        rd(8'h00, v); chk("R1 base reset", v, 32'h0);
        rd(8'h04, v); chk("R10 enables", v, 32'h0);
        rd(8'h08, v); chk("R10 flags", v, 32'h0);
        rd(8'h0C, v); chk("R10 ctrl", v, 32'h0);
        for (int w = 0; w < 8; w++) begin
            rd(8'(8'h10 + 4*w), v); chk("R10 prio", v, 32'h0);
        end
        expect_idle("R9 after reset");

        // R1: relocate base, low bits dropped
        wr(8'h00, 32'h2000_0103);
        base = 32'h2000_0100;
        rd(8'h00, v); chk("R1 base readback", v, base);

        // R2 / R3 / R9: one source at a time
        for (int k = 0; k < N; k++) begin
            wr(8'h04, 32'h1 << k);
            fire(32'h1 << k);
            expect_irq("R2 sweep", k);
            wr(8'h08, 32'h1 << k);
            expect_idle("R3 cleared");
        end
        chk("R2 irq22 slot", base + 32'h98, base + 32'(4 * (22 + 16)));

        // R4: flags latched while disabled, released by enable write
        wr(8'h04, 32'h0);
        fire(32'h0088_0000);
        expect_idle("R4 masked");
        rd(8'h08, v); chk("R3 flags sticky while masked", v, 32'h0088_0000);
        wr(8'h04, 32'h0080_0000);
        expect_irq("R4 enable after flag", 23);
        wr(8'h04, 32'hFFFF_FFFF);
        expect_irq("R6 tie lower index", 19);
        wr(8'h08, 32'hFFFF_FFFF);
        expect_idle("R3 all cleared");

        // R3: clear and event in the same cycle
        fire(32'h0000_0020);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h20; irq_event = 32'h20;
        @(negedge clk);
        wr_en = 1'b0; irq_event = '0;
        rd(8'h08, v); chk("R3 set beats clear", v, 32'h20);
        expect_irq("R3 still requesting", 5);
        wr(8'h08, 32'h20);

        // R5: field storage
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R5 low bits zero", v, 32'hC0C0_C0C0);
        wr(8'h10, 32'h0000_0000);

        // R5 / R6: every pair of codes on sources 3 and 9
        fire(32'h0000_0208);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                wr(8'h10, 32'(a) << 30);
                wr(8'h18, 32'(b) << 14);
                expect_irq((b < a) ? "R5 lower code" : "R6 tie or lower", (b < a) ? 9 : 3);
            end
        end

        // R8: watchdog routed to reset
        @(negedge clk); wdt_event = 1'b1;
        @(negedge clk); wdt_event = 1'b0;
        chk("R8 reset pulse", 32'(sys_reset_req), 32'd1);
        chk("R8 no nmi", 32'(nmi_active), 32'd0);
        @(negedge clk);
        chk("R8 pulse ends", 32'(sys_reset_req), 32'd0);

        // R7: watchdog routed to NMI, beats peripherals, ignores enables
        wr(8'h0C, 32'h1);
        @(negedge clk); wdt_event = 1'b1;
        @(negedge clk); wdt_event = 1'b0;
        chk("R7 nmi pending", 32'(nmi_active), 32'd1);
        chk("R7 no reset", 32'(sys_reset_req), 32'd0);
        chk("R7 exc", 32'(irq_excnum), 32'd2);
        chk("R7 addr", vec_addr, base + 32'h8);
        wr(8'h04, 32'h0);
        chk("R7 enables ignored", 32'(irq_excnum), 32'd2);
        rd(8'h0C, v); chk("R7 ctrl read", v, 32'h3);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h3);
        chk("R7 cleared", 32'(nmi_active), 32'd0);
        expect_irq("R7 back to irq", 3);

        n_run = n_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule